// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel stereo PCM sample pairs into a single serial data line. It does not generate any clocks. An external bit clock (`bclk`) and frame clock (`lrclk`) arrive already synchronous to the system clock `clk`. The block finds each falling edge of the bit clock in the `clk` domain and launches one output bit per falling edge. The far end can therefore sample the line on the following rising edge.

Five framing formats are supported:

- Left-justified, right-justified and I2S carry one word per frame-clock half, with the left word while `lrclk` is high.
- Two frame-sync formats (DSP early and DSP late) pack the left and right words back to back after a rising edge of `lrclk`.

The word length can be 16, 20, 24 or 32 bits. Any bit position that carries no word bit is driven low.

Samples enter through a valid/ready port that holds one waiting pair. `in_ready` is high while the holding slot is empty. A transfer happens on any `clk` edge where both `in_valid` and `in_ready` are high. Once a pair is held, `in_ready` stays low until the next frame start moves that pair into the shifter. A source that drives `in_valid` while `in_ready` is low must keep its data until the transfer happens. If no pair is waiting when a frame starts, the previous pair is sent again and `underrun` pulses.

Top module: `ast_serial_tx`

## Requirements
- R1: During and right after reset, `sdata` is 0, `in_ready` is 1 and `underrun` is 0.
- R2: A bit-clock falling edge is detected on the first `clk` edge where `bclk` is low after having been high at the previous `clk` edge. `sdata` is updated on that `clk` edge and holds its value until the next detected falling edge.
- R3: Left-justified (`fmt`=0): the MSB is launched on the falling edge where `lrclk` changes level. The remaining bits follow MSB first, one per falling edge. Every later bit of that half is 0.
- R4: I2S (`fmt`=2): the launch is the same as in R3 but one bit clock later. The bit at the transition falling edge is 0.
- R5: Right-justified (`fmt`=1): the LSB is launched on the last falling edge before the next `lrclk` change. The half length is taken from the bit-clock count of the previous half-period. Earlier bits are 0, and the output is all zero until one full half-period has been measured.
- R6: In formats 0, 1 and 2, the left word is sent while `lrclk` is high and the right word while it is low.
- R7: DSP late (`fmt`=4): a frame starts on the falling edge where `lrclk` rises, and the left MSB is launched on that edge. The right MSB follows directly after the left LSB. Bits after 2×word length are 0. A falling `lrclk` has no effect on the output.
- R8: DSP early (`fmt`=3): the same as R7, but launched one bit clock later.
- R9: `wlen` selects the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. A sample occupies bits [W-1:0] of its input, and the bits above W are ignored.
- R10: `in_ready` is high exactly when the holding slot is empty. A pair offered while `in_ready` is low is not taken.
- R11: A rising `lrclk` at a falling edge marks a frame start. At a frame start the held pair, if any, becomes the pair sent from that falling edge on, and `in_ready` rises again.
- R12: At a frame start with no held pair, `underrun` is high for exactly one `clk` cycle and the previous pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Format: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP early, 4 DSP late |
| wlen | input | 2 | Word length code (R9) |
| bclk | input | 1 | Bit clock, synchronous to clk |
| lrclk | input | 1 | Frame clock / frame sync, changes with bclk falling |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot empty |
| in_left | input | 32 | Left sample, LSB-aligned |
| in_right | input | 32 | Right sample, LSB-aligned |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: frame started without a new pair |

## Verification
Each serial bit is due on the first `clk` edge after the bench lowers `bclk`. The bench reads `sdata` two `clk` cycles after that edge, away from any edge. It reads `sdata` again at the end of the high phase to confirm the bit did not move. Handshake results are read one `clk` cycle after the transfer edge. The underrun pulses are counted as they occur and compared with the number of frames that started without a fresh pair. Right-justified checks start only in the second frame, once a half-period length has been measured.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPE = 3'd3,
    FMT_DSPL = 3'd4
  } fmt_e;

  function automatic int wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/ast_clk_track.sv
module ast_clk_track #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          lrclk,
  output logic          fall_evt,
  output logic          trans_evt,
  output logic          frame_start,
  output logic [CW-1:0] half_idx,
  output logic [CW:0]   frame_idx,
  output logic [CW-1:0] half_len,
  output logic          len_ok
);
  localparam logic [CW-1:0] HMAX = '1;
  localparam logic [CW:0]   FMAX = '1;

  logic          bclk_q, lr_prev, seen;
  logic [CW-1:0] hcnt;
  logic [CW:0]   fcnt;

  assign fall_evt    = bclk_q & ~bclk;
  assign trans_evt   = fall_evt & (lrclk ^ lr_prev);
  assign frame_start = fall_evt & lrclk & ~lr_prev;
  assign half_idx    = trans_evt ? '0 : ((hcnt == HMAX) ? hcnt : hcnt + 1'b1);
  assign frame_idx   = frame_start ? '0 : ((fcnt == FMAX) ? fcnt : fcnt + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      lr_prev  <= 1'b0;
      seen     <= 1'b0;
      hcnt     <= '0;
      fcnt     <= '0;
      half_len <= '0;
      len_ok   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (fall_evt) begin
        lr_prev <= lrclk;
        hcnt    <= half_idx;
        fcnt    <= frame_idx;
        if (trans_evt) begin
          seen <= 1'b1;
          if (seen) begin
            half_len <= (hcnt == HMAX) ? HMAX : hcnt + 1'b1;
            len_ok   <= 1'b1;
          end
        end
      end
    end
  end

  // R5: a level change restarts the half-period count
  p_trans_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trans_evt |=> (hcnt == '0));
  // R7: a frame sync rise restarts the frame count
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fcnt == '0));
  // R2: counts advance only on detected falling edges
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> ($stable(hcnt) && $stable(fcnt)));
endmodule

// File: rtl/ast_sample_buf.sv
module ast_sample_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  input  logic          load,
  output logic [DW-1:0] cur_l,
  output logic [DW-1:0] cur_r,
  output logic          underrun
);
  logic          full;
  logic [DW-1:0] pend_l, pend_r, act_l, act_r;
  logic          accept;

  assign in_ready = ~full;
  assign accept   = in_valid & ~full;
  assign cur_l    = (load && full) ? pend_l : act_l;
  assign cur_r    = (load && full) ? pend_r : act_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      pend_l   <= '0;
      pend_r   <= '0;
      act_l    <= '0;
      act_r    <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= load & ~full;
      if (load && full) begin
        act_l <= pend_l;
        act_r <= pend_r;
      end
      if (accept) begin
        pend_l <= in_left;
        pend_r <= in_right;
      end
      full <= (full & ~load) | accept;
    end
  end

  // R10: a transfer closes the slot for the next cycle
  p_accept_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R12: an underrun pulse only follows a frame start
  p_underrun_at_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(load));
  // R10: a held pair is not overwritten before a frame start
  p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !load) |=> ($stable(pend_l) && $stable(pend_r)));
endmodule

// File: rtl/ast_bit_pick.sv
module ast_bit_pick
  import ast_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic [2:0]    fmt,
  input  logic [1:0]    wlen,
  input  logic          lr,
  input  logic [CW-1:0] half_idx,
  input  logic [CW:0]   frame_idx,
  input  logic [CW-1:0] half_len,
  input  logic          len_ok,
  input  logic [DW-1:0] word_l,
  input  logic [DW-1:0] word_r,
  output logic          bit_o
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  int            w, k, f, n, j, pos;
  logic [DW-1:0] ch;

  always_comb begin
    w = wl_bits(wlen);
    if (w > DW) w = DW;
    k   = int'(half_idx);
    f   = int'(frame_idx);
    n   = int'(half_len);
    ch  = lr ? word_l : word_r;
    pos = -1;
    j   = -1;
    case (fmt)
      FMT_LJ:  if (k < w) pos = w - 1 - k;
      FMT_I2S: if (k >= 1 && k <= w) pos = w - k;
      FMT_RJ:  if (len_ok && k < n && (n - 1 - k) < w) pos = n - 1 - k;
      FMT_DSPE, FMT_DSPL: begin
        j = (fmt == FMT_DSPE) ? f - 1 : f;
        if (j >= 0 && j < w) begin
          ch  = word_l;
          pos = w - 1 - j;
        end else if (j >= w && j < 2 * w) begin
          ch  = word_r;
          pos = 2 * w - 1 - j;
        end
      end
      default: pos = -1;
    endcase
    bit_o = (pos >= 0) ? ch[pos[IW-1:0]] : 1'b0;
  end
endmodule

// File: rtl/ast_serial_tx.sv
module ast_serial_tx
  import ast_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    fmt,
  input  logic [1:0]    wlen,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          sdata,
  output logic          underrun
);
  logic          fall_evt, trans_evt, frame_start, len_ok, nxt_bit;
  logic [CW-1:0] half_idx, half_len;
  logic [CW:0]   frame_idx;
  logic [DW-1:0] cur_l, cur_r;

  ast_clk_track #(.CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .fall_evt(fall_evt), .trans_evt(trans_evt), .frame_start(frame_start),
    .half_idx(half_idx), .frame_idx(frame_idx),
    .half_len(half_len), .len_ok(len_ok)
  );

  ast_sample_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .load(frame_start),
    .cur_l(cur_l), .cur_r(cur_r), .underrun(underrun)
  );

  ast_bit_pick #(.DW(DW), .CW(CW)) u_pick (
    .fmt(fmt), .wlen(wlen), .lr(lrclk), .half_idx(half_idx),
    .frame_idx(frame_idx), .half_len(half_len), .len_ok(len_ok),
    .word_l(cur_l), .word_r(cur_r), .bit_o(nxt_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        sdata <= 1'b0;
    else if (fall_evt) sdata <= nxt_bit;
  end

  // R2: the line only moves on a detected falling edge
  p_sdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdata));
  // R3: left-justified bits past the word are low
  p_lj_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && fmt == FMT_LJ && int'(half_idx) >= wl_bits(wlen)) |=> !sdata);
  // R4: I2S leaves the transition slot low
  p_i2s_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && trans_evt && fmt == FMT_I2S) |=> !sdata);
endmodule

// File: tb/ast_serial_tx_tb.sv
module ast_serial_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  wlen = 2'd0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_left = '0;
  logic [31:0] in_right = '0;
  logic        sdata;
  logic        underrun;

  int n_tests = 0;
  int n_fail  = 0;
  int ucount  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  ast_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .bclk(bclk),
    .lrclk(lrclk), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .sdata(sdata), .underrun(underrun)
  );

  always @(posedge clk) if (rst_n && underrun) ucount++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int t, input int f, input bit ch);
    logic [31:0] v;
    v = 32'h9E37_79B9 * (t * 8 + f + 1);
    return ch ? (v ^ 32'h5A5A_C3C3) : (v ^ 32'h0137_EF21);
  endfunction

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  // expected serial bit, derived from R3..R8
  function automatic logic eb(input logic [2:0] fc, input int w, input bit lr,
                              input int k, input int fi, input int n,
                              input logic [31:0] L, input logic [31:0] R);
    logic [31:0] c;
    int s;
    c = lr ? L : R;
    case (fc)
      3'd0: return (k < w) ? c[w-1-k] : 1'b0;
      3'd2: return (k >= 1 && k <= w) ? c[w-k] : 1'b0;
      3'd1: return ((n - 1 - k) < w) ? c[n-1-k] : 1'b0;
      default: begin
        s = (fc == 3'd3) ? fi - 1 : fi;
        if (s >= 0 && s < w) return L[w-1-s];
        if (s >= w && s < 2 * w) return R[2*w-1-s];
        return 1'b0;
      end
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b1; lrclk = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ucount = 0;
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r, input string req);
    chk(in_ready == 1'b1, req, "ready before push", {31'b0, in_ready}, 32'd1);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frames(input logic [2:0] fc, input logic [1:0] wc,
                            input int half, input int nf, input int from,
                            input int mask, input bit bp, input int tag,
                            input string req);
    logic [31:0] el[8];
    logic [31:0] er[8];
    int w, exp_u;
    bit dsp;
    logic s1, s2, e;
    fmt = fc; wlen = wc;
    w = wbits(wc);
    dsp = (fc == 3'd3) || (fc == 3'd4);
    do_reset();
    el[0] = gen(tag, 0, 0); er[0] = gen(tag, 0, 1);
    @(negedge clk);
    push(el[0], er[0], "R10");
    if (bp) begin
      chk(in_ready == 1'b0, "R10", "ready low when held", {31'b0, in_ready}, 32'd0);
      in_valid = 1'b1; in_left = 32'hDEAD_BEEF; in_right = 32'hFACE_0FF0;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R10", "ready stays low", {31'b0, in_ready}, 32'd0);
      in_valid = 1'b0;
    end
    for (int f = 0; f < nf; f++) begin
      for (int b = 0; b < 2 * half; b++) begin
        bit lrv;
        int k;
        lrv = dsp ? (b == 0) : (b < half);
        k   = dsp ? b : ((b < half) ? b : b - half);
        @(negedge clk);
        bclk = 1'b0; lrclk = lrv;
        repeat (2) @(negedge clk);
        s1 = sdata;
        if (f >= from) begin
          e = eb(fc, w, lrv, k, b, half, el[f], er[f]);
          chk(s1 == e, req, $sformatf("frame %0d bit %0d", f, b),
              {31'b0, s1}, {31'b0, e});
        end
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        if (b == 2 && f + 1 < 8) begin
          if ((mask >> f) & 1) begin
            el[f+1] = gen(tag, f + 1, 0); er[f+1] = gen(tag, f + 1, 1);
            push(el[f+1], er[f+1], "R11");
            repeat (2) @(negedge clk);
          end else begin
            el[f+1] = el[f]; er[f+1] = er[f];
            repeat (3) @(negedge clk);
          end
        end else begin
          repeat (3) @(negedge clk);
        end
        s2 = sdata;
        if (b == 0)
          chk(s2 == s1, "R2", "held through high phase", {31'b0, s2}, {31'b0, s1});
      end
    end
    exp_u = 0;
    for (int f = 1; f < nf; f++) if (!((mask >> (f - 1)) & 1)) exp_u++;
    chk(ucount == exp_u, "R12", "underrun pulses", ucount, exp_u);
  endtask

  task automatic t_reset();
    do_reset();
    chk(sdata == 1'b0, "R1", "sdata after reset", {31'b0, sdata}, 32'd0);
    chk(in_ready == 1'b1, "R1", "ready after reset", {31'b0, in_ready}, 32'd1);
    chk(underrun == 1'b0, "R1", "underrun after reset", {31'b0, underrun}, 32'd0);
  endtask

  task automatic t_lj();      run_frames(3'd0, 2'd2, 32, 3, 0, 3, 0, 1, "R3 R6 R11"); endtask
  task automatic t_lj16();    run_frames(3'd0, 2'd0, 20, 3, 0, 3, 0, 2, "R9 R3"); endtask
  task automatic t_i2s();     run_frames(3'd2, 2'd1, 24, 3, 0, 3, 0, 3, "R4 R6"); endtask
  task automatic t_rj();      run_frames(3'd1, 2'd0, 24, 3, 1, 3, 0, 4, "R5 R6"); endtask
  task automatic t_rj_full(); run_frames(3'd1, 2'd3, 32, 3, 1, 3, 0, 5, "R5 R9"); endtask
  task automatic t_dspl();    run_frames(3'd4, 2'd0, 16, 3, 0, 3, 0, 6, "R7"); endtask
  task automatic t_dspe();    run_frames(3'd3, 2'd2, 30, 3, 0, 3, 0, 7, "R8"); endtask
  task automatic t_under();
    run_frames(3'd0, 2'd1, 24, 3, 0, 0, 1, 8, "R12 R10");
    chk(in_ready == 1'b1, "R11", "ready after frame start", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lj();
    t_lj16();
    t_i2s();
    t_rj();
    t_rj_full();
    t_dspl();
    t_dspe();
    t_under();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule